// File: doc/BRIEF.md
# Serial-Programmed Control Register Bank

This block holds the static configuration of a transmit datapath in three byte-wide registers (addresses 00h, 01h, 02h) and drives the decoded fields straight to that datapath. Software reaches the registers through a four-signal serial port made of an active-low select, a serial clock, a data pin and an optional separate output pin. A transfer is always one instruction byte and then one data byte, both framed by one low period of the select.

The port configuration is itself held in register 00h. One bit picks the shift order for both bytes. Another bit chooses where read data leaves the block: on the separate output pin, or on the shared data pin, which then turns round for the data phase. Register 00h also carries a self-clearing software reset that restores the two datapath registers, and a read-only copy of the PLL lock input. The serial pins are oversampled by the system clock through synchronizers, so the serial clock must be at least a few times slower than the system clock.

Top module: `spi_ctrl_regbank`

## Requirements
- R1: After the synchronous active-low reset, register 00h reads 00h (apart from its lock bit), 01h reads 04h and 02h reads 00h, and the field outputs match those values.
- R2: An instruction byte has bit 7 set for a read and clear for a write, and bits 4:0 give the address; a write takes effect only once the 16th rising serial clock edge arrives with the select still low, and a frame cut short leaves every register unchanged.
- R3: With 00h bit 6 at 0 both bytes are shifted most significant bit first; with it at 1 both bytes are shifted least significant bit first.
- R4: With 00h bit 7 at 0 read data appears on `spi_sdo_o` with `spi_sdo_oe` high, one bit per falling serial clock edge, while `spi_sdio_oe` stays low.
- R5: With 00h bit 7 at 1 read data appears on `spi_sdio_o` with `spi_sdio_oe` high and `spi_sdo_oe` low; every output enable is low again once the select has been high for a few system clocks.
- R6: A write frame never raises either output enable.
- R7: Writing 00h with bit 5 set returns 01h and 02h to their reset values, stores the other writable bits of 00h as written, and bit 5 always reads 0.
- R8: Bit 1 of 00h reads the synchronized `pll_lock` input (1 = locked) and cannot be written.
- R9: Bit 0 of 00h and bit 3 of 02h are reserved and read 0; writes to addresses 03h to 1Fh change nothing and reads from them return 00h.
- R10: Field outputs: 00h bits 4/3/2 drive `sleep_en`/`pwr_down`/`single_rset`; 01h bits 7:6 `interp_sel`, 5:4 `nco_mode`, 3 `zero_stuff`, 2 `real_mix`, 1 `mix_sign_pos`, 0 `pin8_clk_out`; 02h bits 7 `fmt_offset_bin`, 6 `one_port`, 5 `clk_drive_hi`, 4 `clk_out_inv`, 2 `port_clk_inv`, 1 `iq_sel_inv`, 0 `pair_q_first`.
- R11: The reset input restores register 00h as well, including the bit order and pin mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdio_i | input | 1 | Shared data pin, input side |
| spi_sdio_o | output | 1 | Shared data pin, output value |
| spi_sdio_oe | output | 1 | Shared data pin output enable |
| spi_sdo_o | output | 1 | Separate read data pin value |
| spi_sdo_oe | output | 1 | Separate read data pin enable |
| pll_lock | input | 1 | PLL lock status, asynchronous |
| sleep_en | output | 1 | Converter output currents off |
| pwr_down | output | 1 | Power down all but the port |
| single_rset | output | 1 | Single reference resistor mode |
| interp_sel | output | 2 | Interpolation rate code |
| nco_mode | output | 2 | Modulation frequency code |
| zero_stuff | output | 1 | Zero stuffing enable |
| real_mix | output | 1 | Real mixing (1) or complex (0) |
| mix_sign_pos | output | 1 | Positive complex rotation |
| pin8_clk_out | output | 1 | Shared pin carries data clock |
| fmt_offset_bin | output | 1 | Input data is offset binary |
| one_port | output | 1 | Interleaved single input port |
| clk_drive_hi | output | 1 | Strong data clock driver |
| clk_out_inv | output | 1 | Invert data clock |
| port_clk_inv | output | 1 | Invert single-port clock |
| iq_sel_inv | output | 1 | Invert I/Q select sense |
| pair_q_first | output | 1 | Q before I in each pair |

## Verification
Directed frames use bytes whose bit patterns are not palindromes, written and read back first in one shift order and then in the other, so a reversed or misaligned shifter shows up as a wrong readback. Reads are repeated in both pin modes while the enables are sampled every data bit, which separates a wrong pin choice from wrong data. A software reset frame with other 00h bits set, a truncated frame, reserved bits and unmapped addresses probe the cases where data must not land. A long seeded random mix of reads and writes over all addresses, including writes that switch bit order, pin mode and soft reset in mid-run, is compared against a bench model of the registers.

// File: rtl/spi_regbank_pkg.sv
// Package: shared constants for the serial control register bank.
// Holds register count, default values, writable masks and the bit
// positions of every field. Assumes byte-wide registers.
package spi_regbank_pkg;

    localparam int RB_DATA_W   = 8;
    localparam int RB_ADDR_W   = 5;
    localparam int RB_NUM_REGS = 3;

    // Writable/readable storage mask per register (index = address).
    localparam logic [7:0] REG_MASK [RB_NUM_REGS] = '{8'hDC, 8'hFF, 8'hF7};
    // Reset value per register (index = address).
    localparam logic [7:0] REG_DFLT [RB_NUM_REGS] = '{8'h00, 8'h04, 8'h00};

    // Register 00h: port configuration.
    localparam int CFG_ADDR   = 0;
    localparam int CFG_3WIRE  = 7;
    localparam int CFG_LSB    = 6;
    localparam int CFG_SWRST  = 5;
    localparam int CFG_SLEEP  = 4;
    localparam int CFG_PDN    = 3;
    localparam int CFG_1RSET  = 2;
    localparam int CFG_LOCK   = 1;

    // Register 01h: filter and mixer.
    localparam int MIX_ADDR   = 1;
    localparam int MIX_INTERP = 6;   // two bits, 7:6
    localparam int MIX_NCO    = 4;   // two bits, 5:4
    localparam int MIX_ZSTUFF = 3;
    localparam int MIX_REAL   = 2;
    localparam int MIX_SIGN   = 1;
    localparam int MIX_PIN8   = 0;

    // Register 02h: data port.
    localparam int PRT_ADDR   = 2;
    localparam int PRT_OFFBIN = 7;
    localparam int PRT_ONEP   = 6;
    localparam int PRT_DRIVE  = 5;
    localparam int PRT_CKINV  = 4;
    localparam int PRT_PCKINV = 2;
    localparam int PRT_IQINV  = 1;
    localparam int PRT_QFIRST = 0;

endpackage

// File: rtl/spi_bit_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Each bit is treated independently; callers must not rely on bits of
// the vector arriving in the same cycle. Reset loads RST_VAL.
module spi_bit_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First flop samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_async;
    end

    for (genvar gs = 1; gs < STAGES; gs++) begin : g_stage
        // Further flops settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[gs] <= RST_VAL;
            else        stage_q[gs] <= stage_q[gs-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/spi_serial_engine.sv
// Module: serial frame engine. Detects serial clock edges on synchronized
// inputs, assembles the instruction and data bytes in the configured bit
// order, issues a one-cycle write strobe and shifts read data out on
// falling edges. Assumes the serial clock is much slower than clk and
// that the frame select is held low for the whole two-byte frame.
module spi_serial_engine #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic              lsb_first,
    input  logic              three_wire,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              xfer_rd,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe
);

    localparam int FRAME = 2 * DATA_W;
    localparam int CNT_W = $clog2(FRAME + 1);

    logic              sclk_d;
    logic              rise;
    logic              fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  tx_idx;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] shift_nxt;
    logic [DATA_W-1:0] out_byte;
    logic [ADDR_W-1:0] addr_q;
    logic              dout_q;
    logic              drive_q;

    // Choose the bit of a byte sent at position idx of the data phase.
    function automatic logic pick_bit(input logic [DATA_W-1:0] b,
                                      input logic [CNT_W-1:0]  idx,
                                      input logic              lsb);
        logic r;
        r = 1'b0;
        for (int j = 0; j < DATA_W; j++) begin
            if (lsb ? (idx == CNT_W'(j)) : (idx == CNT_W'(DATA_W - 1 - j)))
                r = b[j];
        end
        return r;
    endfunction

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign rise      = sclk_s & ~sclk_d & ~csn_s;
    assign fall      = ~sclk_s & sclk_d & ~csn_s;
    assign tx_idx    = bit_cnt - CNT_W'(DATA_W);
    assign shift_nxt = lsb_first ? {sdi_s, shift_q[DATA_W-1:1]}
                                 : {shift_q[DATA_W-2:0], sdi_s};

    // Count bits and shift in serial data on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shift_q <= '0;
            addr_q  <= '0;
            xfer_rd <= 1'b0;
        end else if (csn_s) begin
            bit_cnt <= '0;
            xfer_rd <= 1'b0;
        end else if (rise && (bit_cnt < CNT_W'(FRAME))) begin
            shift_q <= shift_nxt;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                xfer_rd <= shift_nxt[DATA_W-1];
                addr_q  <= shift_nxt[ADDR_W-1:0];
            end
        end
    end

    // Issue the write strobe on the last rising edge of a write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (!csn_s && rise && (bit_cnt == CNT_W'(FRAME - 1)) && !xfer_rd) begin
                wr_stb  <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= shift_nxt;
            end
        end
    end

    // Launch read data on falling edges and hold the drive until deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= '0;
            dout_q   <= 1'b0;
            drive_q  <= 1'b0;
        end else if (csn_s) begin
            drive_q  <= 1'b0;
        end else if (fall && xfer_rd && (bit_cnt >= CNT_W'(DATA_W))
                     && (bit_cnt < CNT_W'(FRAME))) begin
            drive_q <= 1'b1;
            if (bit_cnt == CNT_W'(DATA_W)) begin
                out_byte <= rd_data;
                dout_q   <= pick_bit(rd_data, '0, lsb_first);
            end else begin
                dout_q   <= pick_bit(out_byte, tx_idx, lsb_first);
            end
        end
    end

    assign rd_addr = addr_q;
    assign sdio_o  = dout_q;
    assign sdo_o   = dout_q;
    assign sdio_oe = drive_q & three_wire;
    assign sdo_oe  = drive_q & ~three_wire;

endmodule

// File: rtl/spi_reg_file.sv
// Module: register storage with masked writes, software reset of the
// datapath registers and the read-back multiplexer. Assumes the write
// strobe is a single-cycle pulse; the software reset bit is never stored.
module spi_reg_file
    import spi_regbank_pkg::*;
#(
    parameter int DATA_W   = RB_DATA_W,
    parameter int ADDR_W   = RB_ADDR_W,
    parameter int NUM_REGS = RB_NUM_REGS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_stb,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic                             lock_s,
    output logic [DATA_W-1:0]                rd_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  reg_q
);

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              soft_rst;
    logic [DATA_W-1:0] lock_bits;

    assign soft_rst  = wr_stb && (wr_addr == ADDR_W'(CFG_ADDR)) && wr_data[CFG_SWRST];
    assign lock_bits = {{(DATA_W-1){1'b0}}, lock_s} << CFG_LOCK;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = DATA_W'(REG_MASK[gi]);
        localparam logic [DATA_W-1:0] DFLT = DATA_W'(REG_DFLT[gi]) & MASK;

        // Hold one register: hardware reset, masked write, soft reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[gi] <= DFLT;
            else if (wr_stb && (wr_addr == ADDR_W'(gi)))
                regs[gi] <= wr_data & MASK;
            else if (soft_rst && (gi != CFG_ADDR))
                regs[gi] <= DFLT;
        end

        assign reg_q[gi] = regs[gi];
    end

    // Select read data; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = regs[i];
                if (i == CFG_ADDR) rd_data = regs[i] | lock_bits;
            end
        end
    end

endmodule

// File: rtl/spi_ctrl_regbank.sv
// Module: top of the serial control register bank. Synchronizes the
// serial pins and lock input, runs the frame engine against the
// register file and splits the registers into named field outputs.
// Assumes the serial clock half period spans several clk cycles.
module spi_ctrl_regbank
    import spi_regbank_pkg::*;
#(
    parameter int DATA_W      = RB_DATA_W,
    parameter int ADDR_W      = RB_ADDR_W,
    parameter int NUM_REGS    = RB_NUM_REGS,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_csn,
    input  logic       spi_sclk,
    input  logic       spi_sdio_i,
    output logic       spi_sdio_o,
    output logic       spi_sdio_oe,
    output logic       spi_sdo_o,
    output logic       spi_sdo_oe,
    input  logic       pll_lock,
    output logic       sleep_en,
    output logic       pwr_down,
    output logic       single_rset,
    output logic [1:0] interp_sel,
    output logic [1:0] nco_mode,
    output logic       zero_stuff,
    output logic       real_mix,
    output logic       mix_sign_pos,
    output logic       pin8_clk_out,
    output logic       fmt_offset_bin,
    output logic       one_port,
    output logic       clk_drive_hi,
    output logic       clk_out_inv,
    output logic       port_clk_inv,
    output logic       iq_sel_inv,
    output logic       pair_q_first
);

    localparam int SYNC_W = 4;
    // Idle levels: lock 0, data 0, select high, clock low.
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 4'b0010;

    logic [SYNC_W-1:0]               sync_q;
    logic                            sclk_s;
    logic                            csn_s;
    logic                            sdi_s;
    logic                            lock_s;
    logic [ADDR_W-1:0]               rd_addr;
    logic [DATA_W-1:0]               rd_data;
    logic                            wr_stb;
    logic [ADDR_W-1:0]               wr_addr;
    logic [DATA_W-1:0]               wr_data;
    logic                            xfer_rd;
    logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
    logic                            three_wire_cfg;
    logic                            lsb_first_cfg;

    spi_bit_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({pll_lock, spi_sdio_i, spi_csn, spi_sclk}),
        .q_sync  (sync_q)
    );

    assign sclk_s = sync_q[0];
    assign csn_s  = sync_q[1];
    assign sdi_s  = sync_q[2];
    assign lock_s = sync_q[3];

    assign three_wire_cfg = reg_q[CFG_ADDR][CFG_3WIRE];
    assign lsb_first_cfg  = reg_q[CFG_ADDR][CFG_LSB];

    spi_serial_engine #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .csn_s      (csn_s),
        .sdi_s      (sdi_s),
        .lsb_first  (lsb_first_cfg),
        .three_wire (three_wire_cfg),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .xfer_rd    (xfer_rd),
        .sdio_o     (spi_sdio_o),
        .sdio_oe    (spi_sdio_oe),
        .sdo_o      (spi_sdo_o),
        .sdo_oe     (spi_sdo_oe)
    );

    spi_reg_file #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .lock_s  (lock_s),
        .rd_data (rd_data),
        .reg_q   (reg_q)
    );

    // Field outputs taken straight from register storage.
    assign sleep_en       = reg_q[CFG_ADDR][CFG_SLEEP];
    assign pwr_down       = reg_q[CFG_ADDR][CFG_PDN];
    assign single_rset    = reg_q[CFG_ADDR][CFG_1RSET];
    assign interp_sel     = reg_q[MIX_ADDR][MIX_INTERP+1:MIX_INTERP];
    assign nco_mode       = reg_q[MIX_ADDR][MIX_NCO+1:MIX_NCO];
    assign zero_stuff     = reg_q[MIX_ADDR][MIX_ZSTUFF];
    assign real_mix       = reg_q[MIX_ADDR][MIX_REAL];
    assign mix_sign_pos   = reg_q[MIX_ADDR][MIX_SIGN];
    assign pin8_clk_out   = reg_q[MIX_ADDR][MIX_PIN8];
    assign fmt_offset_bin = reg_q[PRT_ADDR][PRT_OFFBIN];
    assign one_port       = reg_q[PRT_ADDR][PRT_ONEP];
    assign clk_drive_hi   = reg_q[PRT_ADDR][PRT_DRIVE];
    assign clk_out_inv    = reg_q[PRT_ADDR][PRT_CKINV];
    assign port_clk_inv   = reg_q[PRT_ADDR][PRT_PCKINV];
    assign iq_sel_inv     = reg_q[PRT_ADDR][PRT_IQINV];
    assign pair_q_first   = reg_q[PRT_ADDR][PRT_QFIRST];

endmodule

// File: rtl/spi_ctrl_regbank_chk.sv
// Module: property checker for the serial control register bank,
// attached to every instance of the top by the bind below.
module spi_ctrl_regbank_chk #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 5,
    parameter int NUM_REGS = 3,
    parameter int CS_GUARD = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           spi_csn,
    input logic                           spi_sdio_oe,
    input logic                           spi_sdo_oe,
    input logic                           xfer_rd,
    input logic                           wr_stb,
    input logic [ADDR_W-1:0]              wr_addr,
    input logic [DATA_W-1:0]              wr_data,
    input logic [NUM_REGS*DATA_W-1:0]     reg_flat,
    input logic [1:0]                     interp_sel,
    input logic [1:0]                     nco_mode,
    input logic                           real_mix,
    input logic                           one_port
);

    logic [3:0] cs_hi_cnt;

    // Count consecutive cycles with the raw select high (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)          cs_hi_cnt <= '0;
        else if (!spi_csn)   cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 4'hF) cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end

    // R1 / R11: registers hold their defaults on the first cycle out of reset.
    a_r1_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_flat == 24'h00_04_00));

    // R5: drivers released once the select has been high long enough.
    a_r5_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt >= 4'(CS_GUARD)) |-> (!spi_sdio_oe && !spi_sdo_oe));

    // R6: a driver is only enabled inside a read frame.
    a_r6_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sdio_oe || spi_sdo_oe) |-> xfer_rd);

    // R2: the write strobe is a single-cycle pulse.
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R7: a soft reset write restores the datapath fields.
    a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (wr_addr == '0) && wr_data[5]) |=>
        (interp_sel == 2'b00 && nco_mode == 2'b00 && real_mix && !one_port));

    // R9: writes to unmapped addresses leave storage untouched.
    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (wr_addr >= ADDR_W'(NUM_REGS))) |=> $stable(reg_flat));

endmodule

bind spi_ctrl_regbank spi_ctrl_regbank_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .CS_GUARD (SYNC_STAGES + 2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_csn     (spi_csn),
    .spi_sdio_oe (spi_sdio_oe),
    .spi_sdo_oe  (spi_sdo_oe),
    .xfer_rd     (xfer_rd),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .reg_flat    (reg_q),
    .interp_sel  (interp_sel),
    .nco_mode    (nco_mode),
    .real_mix    (real_mix),
    .one_port    (one_port)
);

// File: tb/test_spi_ctrl_regbank.sv
// Bench: seeded random and directed serial frames against a register model.
module test_spi_ctrl_regbank;

    localparam int HALF = 6;   // serial half period in system clocks

    logic clk = 1'b0;
    always #10 clk = ~clk;     // 50 MHz

    logic       rst_n = 1'b0;
    logic       spi_csn = 1'b1, spi_sclk = 1'b0, spi_sdio_i = 1'b0, pll_lock = 1'b0;
    logic       spi_sdio_o, spi_sdio_oe, spi_sdo_o, spi_sdo_oe;
    logic       sleep_en, pwr_down, single_rset, zero_stuff, real_mix, mix_sign_pos;
    logic       pin8_clk_out, fmt_offset_bin, one_port, clk_drive_hi, clk_out_inv;
    logic       port_clk_inv, iq_sel_inv, pair_q_first;
    logic [1:0] interp_sel, nco_mode;

    spi_ctrl_regbank i_spi_ctrl_regbank (.*);

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m0, m1, m2;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        case (a)
            5'd0:    return m0 | {6'd0, pll_lock, 1'b0};
            5'd1:    return m1;
            5'd2:    return m2;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [17:0] exp_fields();
        return {m0[4], m0[3], m0[2], m1, m2[7:4], m2[2:0]};
    endfunction

    task automatic model_reset();
        m0 = 8'h00; m1 = 8'h04; m2 = 8'h00;
    endtask

    task automatic model_write(input logic [4:0] a, input logic [7:0] d);
        if (a == 5'd0) begin
            m0 = d & 8'hDC;
            if (d[5]) begin m1 = 8'h04; m2 = 8'h00; end
        end else if (a == 5'd1) m1 = d;
        else if (a == 5'd2)    m2 = d & 8'hF7;
    endtask

    task automatic check_fields(input string req);
        chk(req, "fields", {14'd0, sleep_en, pwr_down, single_rset, interp_sel,
            nco_mode, zero_stuff, real_mix, mix_sign_pos, pin8_clk_out,
            fmt_offset_bin, one_port, clk_drive_hi, clk_out_inv, port_clk_inv,
            iq_sel_inv, pair_q_first}, {14'd0, exp_fields()});
    endtask

    // One frame; nbits < 16 cuts it short. Returns read byte and driver status.
    task automatic frame(input logic rd, input logic [4:0] a, input logic [7:0] d,
                         input int nbits, output logic [7:0] got, output logic oe_ok);
        logic       lsb = m0[6];
        logic       tw  = m0[7];
        logic [7:0] ins = {rd, 2'b00, a};
        got = 8'h00;
        oe_ok = 1'b1;
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i < 8) spi_sdio_i = lsb ? ins[i] : ins[7-i];
            else       spi_sdio_i = lsb ? d[i-8] : d[15-i];
            repeat (HALF) @(negedge clk);
            if (i >= 8) begin
                if (lsb) got[i-8]  = tw ? spi_sdio_o : spi_sdo_o;
                else     got[15-i] = tw ? spi_sdio_o : spi_sdo_o;
                if (rd) begin
                    if (tw && !(spi_sdio_oe && !spi_sdo_oe)) oe_ok = 1'b0;
                    if (!tw && !(spi_sdo_oe && !spi_sdio_oe)) oe_ok = 1'b0;
                end else if (spi_sdio_oe || spi_sdo_oe) oe_ok = 1'b0;
            end
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (8) @(negedge clk);
        if (spi_sdio_oe || spi_sdo_oe) oe_ok = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input string req);
        logic [7:0] g;
        logic       ok;
        frame(1'b0, a, d, 16, g, ok);
        chk("R6", "driver during write", {31'd0, ok}, 32'd1);
        model_write(a, d);
        check_fields(req);
    endtask

    task automatic rd_chk(input logic [4:0] a, input string req);
        logic [7:0] g;
        logic       ok;
        logic       tw = m0[7];
        frame(1'b1, a, 8'h00, 16, g, ok);
        chk(req, "read data", {24'd0, g}, {24'd0, exp_read(a)});
        chk(tw ? "R5" : "R4", "driver select", {31'd0, ok}, 32'd1);
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] g;
        logic       ok;
        void'($urandom(32'd20251));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1, R10: reset state.
        check_fields("R1");
        rd_chk(5'd0, "R1");
        rd_chk(5'd1, "R1");
        rd_chk(5'd2, "R1");

        // R8: lock bit follows input and ignores writes.
        pll_lock = 1'b1;
        repeat (6) @(negedge clk);
        rd_chk(5'd0, "R8");
        wr(5'd0, 8'h02, "R8");
        pll_lock = 1'b0;
        repeat (6) @(negedge clk);
        rd_chk(5'd0, "R8");

        // R2, R10: write and read back, MSB first.
        wr(5'd1, 8'hA5, "R10");
        rd_chk(5'd1, "R2");
        // R9: reserved bit of 02h.
        wr(5'd2, 8'hFF, "R10");
        rd_chk(5'd2, "R9");
        // R9: unmapped addresses.
        wr(5'd5, 8'hFF, "R9");
        wr(5'd31, 8'h00, "R9");
        rd_chk(5'd1, "R9");
        rd_chk(5'd2, "R9");
        rd_chk(5'd5, "R9");
        // R9: reserved bit 0 of 00h.
        wr(5'd0, 8'h01, "R9");
        rd_chk(5'd0, "R9");

        // R2: truncated frame leaves register unchanged.
        frame(1'b0, 5'd1, 8'h3C, 12, g, ok);
        check_fields("R2");
        rd_chk(5'd1, "R2");

        // R3: switch to LSB first and exercise both directions.
        wr(5'd0, 8'h40, "R3");
        wr(5'd1, 8'h1E, "R3");
        rd_chk(5'd1, "R3");
        wr(5'd2, 8'hC3, "R3");
        rd_chk(5'd2, "R3");

        // R5: shared-pin read mode, still LSB first, then MSB first.
        wr(5'd0, 8'hC0, "R5");
        rd_chk(5'd1, "R5");
        wr(5'd0, 8'h80, "R5");
        rd_chk(5'd2, "R5");
        rd_chk(5'd0, "R5");
        chk("R5", "drivers idle", {30'd0, spi_sdio_oe, spi_sdo_oe}, 32'd0);

        // R7: software reset with other bits set.
        wr(5'd1, 8'hFB, "R7");
        wr(5'd0, 8'h38, "R7");
        rd_chk(5'd0, "R7");
        rd_chk(5'd1, "R7");
        rd_chk(5'd2, "R7");

        // Random traffic over all addresses.
        for (int n = 0; n < 280; n++) begin
            logic [4:0] a;
            logic [7:0] d;
            a = (($urandom % 5) == 0) ? 5'($urandom % 32) : 5'($urandom % 3);
            d = 8'($urandom);
            if ($urandom % 2) wr(a, d, "R2");
            else              rd_chk(a, "R3");
        end

        // R11: hardware reset restores 00h too.
        wr(5'd0, 8'hD4, "R11");
        wr(5'd2, 8'h55, "R11");
        hw_reset();
        check_fields("R11");
        rd_chk(5'd0, "R11");
        rd_chk(5'd1, "R11");
        rd_chk(5'd2, "R11");

        finish_run();
    end

endmodule